// File: doc/BRIEF.md
# Planar Memory Write Controller

This block sits between an 8-bit processor data bus and four 8-bit memory planes that share one address. Each byte address holds eight pixels: bit i of plane p is bit p of the 4-bit value of pixel i. Software configures the block through an indexed register file. A pointer port picks a register and a value port then reads or writes it. The block turns processor byte accesses into whole-pixel plane operations.

A memory read fetches all four planes at once into a 32-bit holding latch and returns one plane's byte. A memory write builds a new byte for every plane. Each byte starts from either the rotated processor byte or a solid fill taken from a 4-bit colour. It is then combined with the latched byte of that plane through a selectable logic function. Last, a pixel mask picks, per bit, between the combined result and the latched bit. The usual way to recolour a few pixels is a read, which loads the latch, followed by a write at the same address.

A small sequencer with states IDLE, RD_CAP, WR_PUT and ACK handles the access handshake and the plane timing:
- IDLE→ACK on a register access.
- IDLE→RD_CAP on a memory read, because the planes answer one cycle after they see the address.
- IDLE→WR_PUT on a memory write.
- RD_CAP→ACK after the latch is loaded.
- WR_PUT→ACK after the one-cycle plane write.
- ACK→IDLE unconditionally.

Top module: `planar_wr_ctl`

## Requirements
- R1: After reset, every register at indices 0 to 7 reads 0x00, the pixel mask at index 8 reads 0xFF, the pointer reads 0 and the holding latch is zero.
- R2: A write with `cpu_port`=0 sets the 4-bit pointer, and reading port 0 returns it. Accesses with `cpu_port`=1 read or write the register the pointer names. A port-0 write with `cpu_wide`=1 takes the pointer from `cpu_wdata[3:0]` and in the same access stores `cpu_wdata[15:8]` into that register.
- R3: The register roles by index are: 0 fill colour, 1 fill enable, 2 colour compare, 3 rotate/function, 4 plane select, 5 mode, 6 misc, 7 colour ignore, 8 pixel mask. Fill colour and fill enable keep only bits 3:0, plane select keeps only bits 1:0, and the other bits read 0. Writes to indices 9 to 15 are ignored and those indices read 0x00.
- R4: A memory read loads all four plane bytes into the latch and returns the byte of plane `sel[1:0]`. Plane p uses lanes `[8p+7:8p]` of `pl_rdata` and `pl_wdata`.
- R5: Register 3 bits 2:0 give a right-rotate count from 0 to 7 that is applied to the processor byte on writes.
- R6: For each plane p with fill-enable bit p set, the source byte is 0xFF if fill-colour bit p is 1, and 0x00 otherwise. Planes with the enable bit clear use the rotated byte.
- R7: Register 3 bits 4:3 pick the function of source and latched byte: 00 pass source, 01 AND, 10 OR, 11 XOR.
- R8: Each written bit equals the function result where the pixel mask bit is 1, and the latched bit where it is 0.
- R9: A register access acknowledges in the first cycle after the request is taken. A memory read or write acknowledges in the second cycle. A write raises all four `pl_we` bits for exactly one cycle, and `cpu_ack` is a one-cycle pulse.
- R10: Memory writes leave the holding latch unchanged; only memory reads reload it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ack`, dropped right after it |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_mem | input | 1 | 1 = plane memory, 0 = register ports |
| cpu_port | input | 1 | Register port: 0 = pointer, 1 = value |
| cpu_wide | input | 1 | 16-bit pointer-plus-value write |
| cpu_addr | input | ADDR_W | Plane byte address |
| cpu_wdata | input | 16 | Write data; memory writes use bits 7:0 |
| cpu_rdata | output | 8 | Read data, valid while `cpu_ack` is high |
| cpu_ack | output | 1 | Access complete |
| pl_addr | output | ADDR_W | Shared plane address |
| pl_we | output | 4 | Per-plane write enable |
| pl_wdata | output | 32 | Plane write bytes |
| pl_rdata | input | 32 | Plane read bytes, one cycle after the address |

## Verification
The bench drives each request on a falling edge and then counts falling edges until `cpu_ack` appears. That count must be one for register accesses and two for memory accesses. Read data is sampled on the same falling edge as the acknowledge. For writes, the bench counts the falling edges that see `pl_we` high inside that window, and then inspects its own plane model once the acknowledge has arrived, since the plane store lands on the edge just before it. Because results are read only at those edges, a design that finishes one cycle early or late shows up as a mismatch rather than being hidden.

// File: rtl/planar_wr_pkg.sv
package planar_wr_pkg;
    localparam int NUM_PLANES = 4;
    localparam int NUM_REGS   = 9;
    localparam int IDX_W      = 4;

    localparam int IDX_FILL   = 0;
    localparam int IDX_FEN    = 1;
    localparam int IDX_ROTFN  = 3;
    localparam int IDX_SEL    = 4;
    localparam int IDX_MASK   = 8;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RD_CAP = 2'd1,
        S_WR_PUT = 2'd2,
        S_ACK    = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_AND  = 2'd1,
        FN_OR   = 2'd2,
        FN_XOR  = 2'd3
    } alu_fn_t;

    typedef struct packed {
        logic [3:0] fill_col;
        logic [3:0] fill_en;
        logic [2:0] rot_cnt;
        alu_fn_t    fn;
        logic [1:0] plane_sel;
        logic [7:0] pix_mask;
    } wr_cfg_t;

    function automatic logic [7:0] keep_bits(input int idx);
        if (idx == IDX_FILL || idx == IDX_FEN) return 8'h0F;
        if (idx == IDX_SEL) return 8'h03;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] reset_val(input int idx);
        if (idx == IDX_MASK) return 8'hFF;
        return 8'h00;
    endfunction
endpackage

// File: rtl/gfx_regfile.sv
module gfx_regfile
    import planar_wr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc,
    input  logic        wr,
    input  logic        port,
    input  logic        wide,
    input  logic [15:0] wdata,
    output logic [7:0]  rd_val,
    output wr_cfg_t     cfg
);
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       regs_q [NUM_REGS];
    logic             wr_hit;
    logic [IDX_W-1:0] wr_sel;
    logic [7:0]       wr_val;

    always_comb begin
        wr_hit = 1'b0;
        wr_sel = idx_q;
        wr_val = wdata[7:0];
        if (acc && wr) begin
            if (!port) begin
                wr_hit = wide;
                wr_sel = wdata[IDX_W-1:0];
                wr_val = wdata[15:8];
            end else begin
                wr_hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else if (acc && wr && !port) idx_q <= wdata[IDX_W-1:0];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) regs_q[g] <= reset_val(g);
            else if (wr_hit && wr_sel == IDX_W'(g)) regs_q[g] <= wr_val & keep_bits(g);
        end
    end

    always_comb begin
        rd_val = '0;
        if (!port) begin
            rd_val = 8'(idx_q);
        end else begin
            for (int i = 0; i < NUM_REGS; i++)
                if (idx_q == IDX_W'(i)) rd_val = regs_q[i];
        end
    end

    assign cfg.fill_col  = regs_q[IDX_FILL][3:0];
    assign cfg.fill_en   = regs_q[IDX_FEN][3:0];
    assign cfg.rot_cnt   = regs_q[IDX_ROTFN][2:0];
    assign cfg.fn        = alu_fn_t'(regs_q[IDX_ROTFN][4:3]);
    assign cfg.plane_sel = regs_q[IDX_SEL][1:0];
    assign cfg.pix_mask  = regs_q[IDX_MASK];

    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && wr && !port) |=> $stable(idx_q));
endmodule

// File: rtl/gfx_wr_path.sv
module gfx_wr_path
    import planar_wr_pkg::*;
(
    input  logic [7:0]              cpu_byte,
    input  logic [8*NUM_PLANES-1:0] latch,
    input  wr_cfg_t                 cfg,
    output logic [8*NUM_PLANES-1:0] wdata
);
    logic [15:0] dbl;
    logic [7:0]  rot;

    assign dbl = {cpu_byte, cpu_byte} >> cfg.rot_cnt;
    assign rot = dbl[7:0];

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        logic [7:0] src, lat, res;
        assign lat = latch[8*p +: 8];
        assign src = cfg.fill_en[p] ? {8{cfg.fill_col[p]}} : rot;
        always_comb begin
            unique case (cfg.fn)
                FN_PASS: res = src;
                FN_AND:  res = src & lat;
                FN_OR:   res = src | lat;
                FN_XOR:  res = src ^ lat;
                default: res = src;
            endcase
        end
        assign wdata[8*p +: 8] = (res & cfg.pix_mask) | (lat & ~cfg.pix_mask);
    end
endmodule

// File: rtl/gfx_seq.sv
module gfx_seq
    import planar_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       wr,
    input  logic       mem,
    output seq_state_t state,
    output logic       reg_fire,
    output logic       latch_en,
    output logic       we_en,
    output logic       ack
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req) begin
                    if (!mem)    state_d = S_ACK;
                    else if (wr) state_d = S_WR_PUT;
                    else         state_d = S_RD_CAP;
                end
            end
            S_RD_CAP: state_d = S_ACK;
            S_WR_PUT: state_d = S_ACK;
            S_ACK:    state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        reg_fire = 1'b0;
        latch_en = 1'b0;
        we_en    = 1'b0;
        ack      = 1'b0;
        unique case (state_q)
            S_IDLE:   reg_fire = req && !mem;
            S_RD_CAP: latch_en = 1'b1;
            S_WR_PUT: we_en    = 1'b1;
            S_ACK:    ack      = 1'b1;
            default:  ;
        endcase
    end

    assign state = state_q;

    p_we_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we_en |=> !we_en && ack);
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_read_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> ack);
endmodule

// File: rtl/planar_wr_ctl.sv
module planar_wr_ctl
    import planar_wr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic              cpu_mem,
    input  logic              cpu_port,
    input  logic              cpu_wide,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_ack,
    output logic [ADDR_W-1:0] pl_addr,
    output logic [3:0]        pl_we,
    output logic [31:0]       pl_wdata,
    input  logic [31:0]       pl_rdata
);
    localparam int LANES = 8 * NUM_PLANES;

    seq_state_t       state;
    logic             reg_fire, latch_en, we_en;
    logic [7:0]       reg_rd;
    wr_cfg_t          cfg;
    logic [LANES-1:0] latch_q;
    logic [7:0]       rdata_q;

    gfx_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cpu_req),
        .wr       (cpu_wr),
        .mem      (cpu_mem),
        .state    (state),
        .reg_fire (reg_fire),
        .latch_en (latch_en),
        .we_en    (we_en),
        .ack      (cpu_ack)
    );

    gfx_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (reg_fire),
        .wr     (cpu_wr),
        .port   (cpu_port),
        .wide   (cpu_wide),
        .wdata  (cpu_wdata),
        .rd_val (reg_rd),
        .cfg    (cfg)
    );

    gfx_wr_path u_wpath (
        .cpu_byte (cpu_wdata[7:0]),
        .latch    (latch_q),
        .cfg      (cfg),
        .wdata    (pl_wdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (latch_en) latch_q <= pl_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (reg_fire && !cpu_wr) rdata_q <= reg_rd;
        else if (latch_en)           rdata_q <= pl_rdata[8*cfg.plane_sel +: 8];
    end

    assign cpu_rdata = rdata_q;
    assign pl_addr   = cpu_addr;
    assign pl_we     = {NUM_PLANES{we_en}};

    p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_we != 4'h0) |=> $stable(latch_q));
    p_unmasked_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_we != 4'h0) |-> (((pl_wdata ^ latch_q) & ~{NUM_PLANES{cfg.pix_mask}}) == '0));
    p_we_in_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_we != 4'h0) |-> (state == S_WR_PUT));
endmodule

// File: tb/planar_wr_ctl_tb.sv
module planar_wr_ctl_tb;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_wr = 1'b0, cpu_mem = 1'b0, cpu_port = 1'b0, cpu_wide = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0]   cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic          cpu_ack;
    logic [AW-1:0] pl_addr;
    logic [3:0]    pl_we;
    logic [31:0]   pl_wdata;
    logic [31:0]   pl_rdata = '0;

    logic [7:0] ram [0:3][0:15];
    int checks = 0, failures = 0;
    bit done = 0;
    int last_cnt, last_we;

    always #5 clk = ~clk;

    planar_wr_ctl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_mem(cpu_mem),
        .cpu_port(cpu_port), .cpu_wide(cpu_wide), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .pl_addr(pl_addr), .pl_we(pl_we),
        .pl_wdata(pl_wdata), .pl_rdata(pl_rdata)
    );

    always @(posedge clk) begin
        for (int p = 0; p < 4; p++)
            if (pl_we[p]) ram[p][pl_addr] <= pl_wdata[8*p +: 8];
        pl_rdata <= {ram[3][pl_addr], ram[2][pl_addr], ram[1][pl_addr], ram[0][pl_addr]};
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input bit mem, input bit wr, input bit port, input bit wide,
                          input logic [AW-1:0] a, input logic [15:0] d, output logic [7:0] q);
        int cnt = 0, wec = 0;
        @(negedge clk);
        cpu_req = 1; cpu_mem = mem; cpu_wr = wr; cpu_port = port; cpu_wide = wide;
        cpu_addr = a; cpu_wdata = d;
        do begin
            @(negedge clk);
            cnt++;
            if (pl_we != 4'h0) wec++;
        end while (!cpu_ack && cnt < 20);
        q = cpu_rdata;
        cpu_req = 0; cpu_wide = 0;
        last_cnt = cnt; last_we = wec;
    endtask

    task automatic set_reg(input int idx, input logic [7:0] v);
        logic [7:0] q;
        access(0, 1, 0, 1, '0, {v, 8'(idx)}, q);
    endtask

    task automatic get_reg(input int idx, output logic [7:0] q);
        access(0, 1, 0, 0, '0, 16'(idx), q);
        access(0, 0, 1, 0, '0, '0, q);
    endtask

    function automatic logic [7:0] rotr(input logic [7:0] b, input int n);
        logic [15:0] w = {8'h00, b};
        w = (w >> n) | (w << (8 - n));
        return w[7:0];
    endfunction

    function automatic logic [7:0] exp_plane(input int p, input logic [7:0] d, input int rc, input int fn,
                                             input logic [3:0] col, input logic [3:0] en,
                                             input logic [7:0] m, input logic [7:0] lat);
        logic [7:0] src, r;
        src = en[p] ? {8{col[p]}} : rotr(d, rc);
        case (fn)
            0: r = src;
            1: r = src & lat;
            2: r = src | lat;
            default: r = src ^ lat;
        endcase
        return (r & m) | (lat & ~m);
    endfunction

    task automatic do_write(input int rc, input int fn, input logic [3:0] col, input logic [3:0] en,
                            input logic [7:0] m, input logic [7:0] d, input int k, input string tag);
        logic [7:0] q, lat[4], e;
        for (int p = 0; p < 4; p++) begin
            lat[p] = 8'(37 * k + 61 * p + 5);
            ram[p][1] = lat[p];
            ram[p][2] = ~lat[p] ^ 8'h5A;
        end
        set_reg(3, 8'({fn[1:0], rc[2:0]}));
        set_reg(0, {4'h0, col});
        set_reg(1, {4'h0, en});
        set_reg(8, m);
        access(1, 0, 0, 0, 4'd1, '0, q);
        access(1, 1, 0, 0, 4'd2, {8'h00, d}, q);
        for (int p = 0; p < 4; p++) begin
            e = exp_plane(p, d, rc, fn, col, en, m, lat[p]);
            chk(ram[p][2] == e, tag, 32'(ram[p][2]), 32'(e));
        end
    endtask

    initial begin
        logic [7:0] q;
        int n;
        for (int p = 0; p < 4; p++)
            for (int a = 0; a < 16; a++) ram[p][a] = 8'(a * 16 + p * 3 + 1);
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset values and R2 pointer read
        access(0, 0, 0, 0, '0, '0, q);
        chk(q == 8'h00 && last_cnt == 1, "R1 pointer", 32'(q), 32'h0);
        for (int i = 0; i < 9; i++) begin
            get_reg(i, q);
            chk(q == (i == 8 ? 8'hFF : 8'h00), "R1 reset reg", 32'(q), (i == 8 ? 32'hFF : 32'h0));
        end
        // R1: latch zero after reset: write with mask 0 copies latch
        set_reg(8, 8'h00);
        access(1, 1, 0, 0, 4'd5, 16'h00A5, q);
        for (int p = 0; p < 4; p++)
            chk(ram[p][5] == 8'h00, "R1 latch zero", 32'(ram[p][5]), 32'h0);
        set_reg(8, 8'hFF);

        // R3: kept bits and unused indices
        for (int i = 0; i < 16; i++) begin
            set_reg(i, 8'hFF);
            get_reg(i, q);
            chk(q == (i > 8 ? 8'h00 : (i < 2 ? 8'h0F : (i == 4 ? 8'h03 : 8'hFF))), "R3 readback",
                32'(q), 32'(i > 8 ? 8'h00 : (i < 2 ? 8'h0F : (i == 4 ? 8'h03 : 8'hFF))));
        end
        get_reg(8, q);
        chk(q == 8'hFF, "R3 unused index no effect", 32'(q), 32'hFF);

        // R2: separate pointer/value writes and wide write
        access(0, 1, 0, 0, '0, 16'h0005, q);
        access(0, 1, 1, 0, '0, 16'h00C3, q);
        access(0, 0, 0, 0, '0, '0, q);
        chk(q == 8'h05, "R2 pointer", 32'(q), 32'h5);
        access(0, 0, 1, 0, '0, '0, q);
        chk(q == 8'hC3, "R2 value port", 32'(q), 32'hC3);
        access(0, 1, 0, 1, '0, 16'h5A07, q);
        access(0, 0, 0, 0, '0, '0, q);
        chk(q == 8'h07, "R2 wide pointer", 32'(q), 32'h7);
        access(0, 0, 1, 0, '0, '0, q);
        chk(q == 8'h5A && last_cnt == 1, "R2 wide value", 32'(q), 32'h5A);

        // R4 + R9: read sweep over plane select and addresses
        for (int s = 0; s < 4; s++) begin
            set_reg(4, 8'(s));
            for (int a = 0; a < 16; a++) begin
                access(1, 0, 0, 0, 4'(a), '0, q);
                chk(q == ram[s][a], "R4 read byte", 32'(q), 32'(ram[s][a]));
                chk(last_cnt == 2, "R9 read latency", 32'(last_cnt), 32'd2);
            end
        end
        // R4: latch holds all planes (mask 0 copy out)
        set_reg(0, 8'h00); set_reg(1, 8'h00); set_reg(3, 8'h00); set_reg(8, 8'h00);
        access(1, 0, 0, 0, 4'd9, '0, q);
        access(1, 1, 0, 0, 4'd12, 16'h0033, q);
        chk(last_cnt == 2 && last_we == 1, "R9 write timing", 32'({last_cnt, last_we}), 32'h0201);
        for (int p = 0; p < 4; p++)
            chk(ram[p][12] == ram[p][9], "R4 latch all planes", 32'(ram[p][12]), 32'(ram[p][9]));

        // R5 + R7 + R8: rotate, function, mask sweep with fill disabled
        n = 0;
        for (int rc = 0; rc < 8; rc++)
            for (int fn = 0; fn < 4; fn++)
                for (int mi = 0; mi < 3; mi++) begin
                    do_write(rc, fn, 4'h0, 4'h0, (mi == 0) ? 8'hFF : (mi == 1 ? 8'h0F : 8'hA6),
                             8'(n * 29 + 3), n, "R5/R7/R8 data path");
                    n++;
                end

        // R6: fill enable / colour sweep
        for (int en = 0; en < 16; en++)
            for (int col = 0; col < 16; col++) begin
                do_write(3, (en + col) % 4, 4'(col), 4'(en), 8'h3C, 8'(en * 17 + col), n,
                         "R6 fill substitution");
                n++;
            end

        // R10: a write does not reload the latch
        set_reg(1, 8'h00); set_reg(3, 8'h00); set_reg(8, 8'hFF);
        access(1, 0, 0, 0, 4'd3, '0, q);
        access(1, 1, 0, 0, 4'd7, 16'h00E1, q);
        set_reg(8, 8'h00);
        access(1, 1, 0, 0, 4'd8, 16'h0000, q);
        for (int p = 0; p < 4; p++)
            chk(ram[p][8] == ram[p][3], "R10 latch kept", 32'(ram[p][8]), 32'(ram[p][3]));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1500000ns;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule